// File: doc/BRIEF.md
# Transmit Reset and Power-Down Sequencer

This block decides when a transmit datapath may run. It collects the reset and power-down requests that reach the transmit side: an asynchronous active-low hardware reset line, an asynchronous active-low power-down line, a software reset strobe and a software transmit-off level from the register file, a PLL-settled flag and a multiplier-change strobe. From these it drives the clock-gate enable for the transmit datapath, the reset line that holds the CIC interpolator, the reset pulses for the register file and the flag that tells the data source that samples will be used.

The two asynchronous lines pass through two-flop synchronizers. A hardware reset counts only after it has stayed low for a minimum number of system clocks. Shorter glitches are ignored. When power-down ends, the CIC stays in reset for a fixed number of MCLK-rate strobes so that the half-band stages can fill with fresh data. After any reset or multiplier change, a settle timer runs before the ready flag may come back. A software reset clears every register except the control register that holds the software reset bit itself. A hardware reset clears the control register too.

Top module: `tx_pwr_seq`

## Requirements
- R1: `pwrdn_n` and `hw_rst_n` are each sampled by a two-flop synchronizer. A falling `pwrdn_n` that is driven between edges first shows on `tx_clk_en` after the third rising clock edge.
- R2: While the synchronized `pwrdn_n` is low, `tx_clk_en` is 0, `cic_rst` is 1 and `tx_ready` is 0.
- R3: `sw_txoff` = 1 acts like the power-down pin with no synchronizer. At the next edge `tx_clk_en` drops to 0, `cic_rst` rises to 1 and `tx_ready` drops to 0.
- R4: After power-down ends, `cic_rst` stays 1 until exactly HOLD_MCLK cycles with `mclk_en` = 1 have occurred. It falls at the edge that takes the last strobe. After HOLD_MCLK-1 strobes it is still 1.
- R5: `mclk_en` strobes that arrive while power-down is active do not shorten the hold of R4.
- R6: A `hw_rst_n` low pulse that gives fewer than MIN_RST_CYC consecutive low synchronized samples has no effect on any output.
- R7: A `hw_rst_n` low that lasts at least MIN_RST_CYC synchronized samples gates the clock and clears `tx_ready` while it lasts. On its release, `regs_rst` and `ctrl_rst` are both 1 for exactly one cycle.
- R8: A one-cycle `sw_reset` gives a one-cycle `regs_rst` at the next edge. In that cycle `ctrl_rst` stays 0 and `tx_ready` drops to 0.
- R9: `tx_ready` is 0 one edge after `pll_settled` is 0. If every other condition already holds, it returns one edge after `pll_settled` is 1 again.
- R10: After a one-cycle `mult_chg`, `tx_ready` is 0 for the next SETTLE_CYC-1 edges and returns at edge number SETTLE_CYC, counting the edge that samples `mult_chg` as edge 0.
- R11: `tx_ready` rises at the same edge where the last of its conditions is met. Whenever `tx_ready` is 1, `tx_clk_en` is 1 and `cic_rst` is 0.
- R12: While `rst` is asserted, `tx_clk_en` = 0, `cic_rst` = 1, `regs_rst` = 1, `ctrl_rst` = 1 and `tx_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset request |
| pwrdn_n | input | 1 | Asynchronous active-low transmit power-down pin |
| sw_reset | input | 1 | One-cycle software reset strobe from the register file |
| sw_txoff | input | 1 | Software transmit-off level from the register file |
| pll_settled | input | 1 | PLL lock indication |
| mult_chg | input | 1 | One-cycle strobe marking a change of the PLL multiplier |
| mclk_en | input | 1 | One-cycle enable at the MCLK rate |
| tx_clk_en | output | 1 | Clock-gate enable for the transmit datapath |
| cic_rst | output | 1 | Reset for the CIC interpolator |
| regs_rst | output | 1 | Reset pulse for all registers except the control register |
| ctrl_rst | output | 1 | Reset pulse for the control register |
| tx_ready | output | 1 | Transmit data will be used |

## Verification
The hardest property to observe is the exact length of the post-power-down CIC hold. The hold counter also reloads during power-down and moves on every MCLK strobe, so a free-running strobe would blur the edge that matters. The bench therefore lets strobes run during power-down to show that they do not count. It then stops the strobe source, releases the pin and waits for the clock gate to open. After that it issues strobes one at a time, checks `cic_rst` after strobe 79, and checks that `cic_rst` and `tx_ready` change together after strobe 80. The settle window is measured the same way, by counting edges from a lone `mult_chg`.

// File: rtl/tps_pkg.sv
package tps_pkg;
  // Causes that restart the whole transmit side.
  typedef struct packed {
    logic hw_rel;
    logic sw_rst;
  } rst_evt_t;

  function automatic logic any_evt(input rst_evt_t e);
    return e.hw_rel | e.sw_rst;
  endfunction
endpackage

// File: rtl/tps_sync.sv
module tps_sync #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{INIT}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/tps_rst_filter.sv
module tps_rst_filter #(
  parameter int MIN_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_n_s,
  output logic act,
  output logic rel
);
  localparam int W = $clog2(MIN_CYC + 1);

  logic [W-1:0] lowcnt;
  logic         act_q;

  always_ff @(posedge clk) begin
    if (rst || rst_n_s) begin
      lowcnt <= '0;
      act_q  <= 1'b0;
    end else begin
      if (lowcnt != W'(MIN_CYC)) lowcnt <= lowcnt + W'(1);
      if (lowcnt == W'(MIN_CYC - 1)) act_q <= 1'b1;
    end
  end

  assign act = act_q;
  assign rel = act_q & rst_n_s;

  // R6: qualification only ever follows a low sample
  assert_short_pulse_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q) |-> $past(!rst_n_s));
endmodule

// File: rtl/tps_down_timer.sv
module tps_down_timer #(
  parameter int LIMIT = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  output logic zero_nxt
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt, cnt_nxt;

  always_comb begin
    if (load)                    cnt_nxt = W'(LIMIT);
    else if (step && cnt != '0)  cnt_nxt = cnt - W'(1);
    else                         cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= W'(LIMIT);
    else     cnt <= cnt_nxt;
  end

  assign zero_nxt = (cnt_nxt == '0);

  // R4: counter never leaves its range
  assert_timer_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= W'(LIMIT));
endmodule

// File: rtl/tx_pwr_seq.sv
module tx_pwr_seq #(
  parameter int MIN_RST_CYC = 13,
  parameter int HOLD_MCLK   = 80,
  parameter int SETTLE_CYC  = 125000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_rst_n,
  input  logic pwrdn_n,
  input  logic sw_reset,
  input  logic sw_txoff,
  input  logic pll_settled,
  input  logic mult_chg,
  input  logic mclk_en,
  output logic tx_clk_en,
  output logic cic_rst,
  output logic regs_rst,
  output logic ctrl_rst,
  output logic tx_ready
);
  import tps_pkg::*;

  logic pwr_s, hw_s, hw_act, hw_rel;
  logic pd_c, hold_z, settle_z;
  rst_evt_t evt;

  tps_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_pd (
    .clk(clk), .rst(rst), .d(pwrdn_n), .q(pwr_s));

  tps_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_hw (
    .clk(clk), .rst(rst), .d(hw_rst_n), .q(hw_s));

  tps_rst_filter #(.MIN_CYC(MIN_RST_CYC)) u_filt (
    .clk(clk), .rst(rst), .rst_n_s(hw_s), .act(hw_act), .rel(hw_rel));

  assign evt.hw_rel = hw_rel;
  assign evt.sw_rst = sw_reset;

  assign pd_c = hw_act | ~pwr_s | sw_txoff;

  // CIC flush hold, counted in MCLK strobes after power-down ends
  tps_down_timer #(.LIMIT(HOLD_MCLK)) u_hold (
    .clk(clk), .rst(rst), .load(pd_c | any_evt(evt)), .step(mclk_en),
    .zero_nxt(hold_z));

  // PLL settle window, counted in system clocks
  tps_down_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .load(any_evt(evt) | mult_chg | hw_act), .step(1'b1),
    .zero_nxt(settle_z));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_clk_en <= 1'b0;
      cic_rst   <= 1'b1;
      regs_rst  <= 1'b1;
      ctrl_rst  <= 1'b1;
      tx_ready  <= 1'b0;
    end else begin
      tx_clk_en <= ~pd_c;
      cic_rst   <= ~hold_z;
      regs_rst  <= any_evt(evt);
      ctrl_rst  <= evt.hw_rel;
      tx_ready  <= ~pd_c & hold_z & settle_z & pll_settled;
    end
  end

  // R2: synchronized power-down closes the gate and holds the CIC
  assert_pd_gates_clk_R2: assert property (@(posedge clk) disable iff (rst)
    !pwr_s |=> (!tx_clk_en && cic_rst));
  // R3: software transmit-off acts at the next edge
  assert_swoff_gates_R3: assert property (@(posedge clk) disable iff (rst)
    sw_txoff |=> !tx_clk_en);
  // R4: CIC is held whenever the clock gate is shut
  assert_clkoff_holds_cic_R4: assert property (@(posedge clk) disable iff (rst)
    !tx_clk_en |-> cic_rst);
  // R8: software reset spares the control register
  assert_swrst_spares_ctrl_R8: assert property (@(posedge clk) disable iff (rst)
    (sw_reset && !hw_rel) |=> (regs_rst && !ctrl_rst && !tx_ready));
  // R9: ready needs lock
  assert_ready_needs_pll_R9: assert property (@(posedge clk) disable iff (rst)
    !pll_settled |=> !tx_ready);
  // R10: multiplier change drops ready
  assert_mchg_drops_ready_R10: assert property (@(posedge clk) disable iff (rst)
    mult_chg |=> !tx_ready);
  // R11: ready only with an open gate and a released CIC
  assert_ready_clean_R11: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (tx_clk_en && !cic_rst));
endmodule

// File: tb/tb_tx_pwr_seq.sv
module tb_tx_pwr_seq;
  localparam int MIN_C  = 13;
  localparam int HOLD   = 80;
  localparam int SETTLE = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hw_rst_n = 1'b1, pwrdn_n = 1'b1, sw_reset = 1'b0, sw_txoff = 1'b0;
  logic pll_settled = 1'b1, mult_chg = 1'b0;
  logic mclk_run = 1'b1, mclk_man = 1'b0;
  logic [1:0] div = 2'd0;
  logic mclk_en;
  logic tx_clk_en, cic_rst, regs_rst, ctrl_rst, tx_ready;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) div <= div + 2'd1;
  assign mclk_en = (mclk_run && div == 2'd0) | mclk_man;

  tx_pwr_seq #(.MIN_RST_CYC(MIN_C), .HOLD_MCLK(HOLD), .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst(rst), .hw_rst_n(hw_rst_n), .pwrdn_n(pwrdn_n),
    .sw_reset(sw_reset), .sw_txoff(sw_txoff), .pll_settled(pll_settled),
    .mult_chg(mult_chg), .mclk_en(mclk_en), .tx_clk_en(tx_clk_en),
    .cic_rst(cic_rst), .regs_rst(regs_rst), .ctrl_rst(ctrl_rst),
    .tx_ready(tx_ready));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!tx_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " ready returns"}, int'(tx_ready), 1);
  endtask

  task automatic strobe();
    @(negedge clk) mclk_man = 1'b1;
    @(negedge clk) mclk_man = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R12 tx_clk_en", int'(tx_clk_en), 0);
    chk("R12 cic_rst", int'(cic_rst), 1);
    chk("R12 regs_rst", int'(regs_rst), 1);
    chk("R12 ctrl_rst", int'(ctrl_rst), 1);
    chk("R12 tx_ready", int'(tx_ready), 0);
  endtask

  task automatic t_pin_pd_hold();
    int n;
    @(negedge clk) pwrdn_n = 1'b0;
    @(negedge clk); chk("R1 edge1 gate", int'(tx_clk_en), 1);
    @(negedge clk); chk("R1 edge2 gate", int'(tx_clk_en), 1);
    @(negedge clk); chk("R1 edge3 gate", int'(tx_clk_en), 0);
    repeat (100) @(negedge clk);
    chk("R2 gate", int'(tx_clk_en), 0);
    chk("R2 cic", int'(cic_rst), 1);
    chk("R2 ready", int'(tx_ready), 0);
    mclk_run = 1'b0;
    pwrdn_n  = 1'b1;
    n = 0;
    while (!tx_clk_en && n < 10) begin
      @(negedge clk);
      n++;
    end
    chk("R2 gate reopens", int'(tx_clk_en), 1);
    repeat (3) @(negedge clk);
    chk("R5 cic still held", int'(cic_rst), 1);
    for (int i = 0; i < HOLD - 1; i++) strobe();
    chk("R4 cic after HOLD-1", int'(cic_rst), 1);
    chk("R11 ready before last strobe", int'(tx_ready), 0);
    strobe();
    chk("R4 cic after HOLD", int'(cic_rst), 0);
    chk("R11 ready with last strobe", int'(tx_ready), 1);
    mclk_run = 1'b1;
  endtask

  task automatic t_swoff();
    @(negedge clk) sw_txoff = 1'b1;
    @(negedge clk);
    chk("R3 gate", int'(tx_clk_en), 0);
    chk("R3 cic", int'(cic_rst), 1);
    chk("R3 ready", int'(tx_ready), 0);
    sw_txoff = 1'b0;
    wait_ready("R3");
  endtask

  task automatic t_pll();
    @(negedge clk) pll_settled = 1'b0;
    @(negedge clk); chk("R9 ready drops", int'(tx_ready), 0);
    pll_settled = 1'b1;
    @(negedge clk); chk("R9 ready back", int'(tx_ready), 1);
  endtask

  task automatic t_mchg();
    int n = 0;
    @(negedge clk) mult_chg = 1'b1;
    @(negedge clk);
    chk("R10 ready drops", int'(tx_ready), 0);
    mult_chg = 1'b0;
    while (!tx_ready && n < SETTLE + 50) begin
      @(negedge clk);
      n++;
    end
    chk("R10 settle length", n, SETTLE);
  endtask

  task automatic t_swrst();
    @(negedge clk) sw_reset = 1'b1;
    @(negedge clk);
    sw_reset = 1'b0;
    chk("R8 regs_rst", int'(regs_rst), 1);
    chk("R8 ctrl_rst", int'(ctrl_rst), 0);
    chk("R8 ready", int'(tx_ready), 0);
    @(negedge clk);
    chk("R8 one cycle", int'(regs_rst), 0);
    wait_ready("R8");
  endtask

  task automatic t_short_hw();
    int bad = 0;
    @(negedge clk) hw_rst_n = 1'b0;
    repeat (5) @(negedge clk);
    hw_rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!tx_ready || !tx_clk_en || regs_rst || ctrl_rst || cic_rst) bad++;
    end
    chk("R6 glitch ignored", bad, 0);
  endtask

  task automatic t_long_hw();
    int n = 0;
    @(negedge clk) hw_rst_n = 1'b0;
    repeat (40) @(negedge clk);
    chk("R7 gate", int'(tx_clk_en), 0);
    chk("R7 ready", int'(tx_ready), 0);
    hw_rst_n = 1'b1;
    while (!regs_rst && n < 8) begin
      @(negedge clk);
      n++;
    end
    chk("R7 regs_rst pulse", int'(regs_rst), 1);
    chk("R7 ctrl_rst pulse", int'(ctrl_rst), 1);
    @(negedge clk);
    chk("R7 pulse width", int'(regs_rst | ctrl_rst), 0);
    wait_ready("R7");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    wait_ready("R11 start");
    t_pin_pd_hold();
    t_swoff();
    t_pll();
    t_mchg();
    t_swrst();
    t_short_hw();
    t_long_hw();
    finish_run();
  end
endmodule